// File: doc/BRIEF.md
# Thermometer-to-Binary Encoder with Bubble Correction

This block sits behind the comparator bank of a parallel (flash) converter. It takes the 2^N-1 comparator decisions as one thermometer word and returns the N-bit binary result. An isolated out-of-sequence bit, whether a false zero inside the run of ones or a stray one above it, is repaired before encoding. This lets a comparator that resolved late or wrongly still give the intended code.

Each comparator bit lands in exactly one flop on the sample strobe. Only that registered copy fans out to the repair and encoding logic, so a bit that is still settling is seen by a single consumer. Repair runs in two steps. First, a zero whose neighbours are both one is filled. Then, a one whose neighbours in the filled word are both zero is cleared. The repaired word is turned into a one-hot marker at its 1-to-0 edge, and an OR-tree maps that marker to binary. The result and a one-cycle valid pulse leave through an output register.

Top module: `thermo_bin_encoder`

## Requirements
- R1: Parameter N (2 to 8, default 3) sets `code_o` to N bits and `therm_i` to 2^N-1 bits. Bit i of `therm_i` is the comparator with the (i+1)-th lowest threshold, so full scale is 2^N-1.
- R2: A clean word with k ones in bits 0..k-1 and zeros above encodes to k. This holds for every k from 0 (all zeros gives 0) up to 2^N-1 (all ones gives full scale).
- R3: A zero whose lower and upper neighbours are both one is treated as one. The neighbour below bit 0 counts as one. For example, a run of four with bit 2 cleared (binary 0001011) encodes to 4.
- R4: After R3 is applied, a one whose lower and upper neighbours are both zero is treated as zero. The neighbour above the top bit counts as zero. A clean run of k plus a stray one at bit k+2 or higher encodes to k.
- R5: R3 is applied before R4. A clean run of k plus a one at bit k+1 therefore fills the gap at bit k and encodes to k+2.
- R6: A word sampled at the clock edge where `sample_i` is high appears on `code_o` one edge later, with `valid_o` high for exactly that one cycle. Strobes on consecutive cycles give results on consecutive cycles, in order.
- R7: `therm_i` is ignored while `sample_i` is low. `code_o` keeps its last result, and `valid_o` stays low, until the next sampled word comes out.
- R8: A synchronous active-high `rst` clears `code_o` to 0 and `valid_o` to 0. A strobe given in a cycle where `rst` is high produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_i | input | 1 | Sample strobe for the comparator word |
| therm_i | input | 2^N-1 | Comparator decisions, bit 0 is the lowest threshold |
| code_o | output | N | Binary result |
| valid_o | output | 1 | One-cycle pulse marking a new result |

## Verification
Filling a false zero and clearing a stray one can both act on the same word in the same cycle. A clean run with an extra one two places above its top does this: the gap is filled and nothing is cleared, so the word reads as a longer run. The sweep builds every clean code and every single-bit flip of it. It computes the expected count from the run length and the flip position alone, so the fill-first order is judged directly. A second overlap comes from back-to-back strobes, where a new capture and an output update land on the same edge. A streaming pass checks those results cycle by cycle.

// File: rtl/therm_enc_pkg.sv
package therm_enc_pkg;

    localparam int unsigned TE_MIN_BITS = 2;
    localparam int unsigned TE_MAX_BITS = 8;

    // a zero framed by ones becomes one
    function automatic logic te_fill(input logic lower, input logic self, input logic upper);
        return self | (lower & upper);
    endfunction

    // a one framed by zeros becomes zero
    function automatic logic te_keep(input logic lower, input logic self, input logic upper);
        return self & (lower | upper);
    endfunction

endpackage

// File: rtl/te_capture.sv
module te_capture #(
    parameter int unsigned W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sample_i,
    input  logic [W-1:0] therm_i,
    output logic [W-1:0] word_o,
    output logic         vld_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            word_o <= '0;
            vld_o  <= 1'b0;
        end else begin
            vld_o <= sample_i;
            if (sample_i) begin
                word_o <= therm_i;
            end
        end
    end

    // R6
    strobe_taken_chk: assert property (@(posedge clk) disable iff (rst)
        sample_i |=> vld_o);

endmodule

// File: rtl/te_bubble_fix.sv
module te_bubble_fix
    import therm_enc_pkg::*;
#(
    parameter int unsigned W = 7
) (
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] fix_o
);

    logic [W+1:0] raw_ext;
    logic [W-1:0] filled;
    logic [W+1:0] fill_ext;

    assign raw_ext = {1'b0, raw_i, 1'b1};

    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_fill
            assign filled[gi] = te_fill(raw_ext[gi], raw_ext[gi+1], raw_ext[gi+2]);
        end
    endgenerate

    assign fill_ext = {1'b0, filled, 1'b1};

    generate
        for (gi = 0; gi < W; gi++) begin : g_keep
            assign fix_o[gi] = te_keep(fill_ext[gi], fill_ext[gi+1], fill_ext[gi+2]);
        end
    endgenerate

    // R2: a clean word passes unchanged
    always_comb begin
        if (!$isunknown(raw_i) && ((raw_i & (raw_i + W'(1))) == '0)) begin
            clean_pass_chk: assert (fix_o == raw_i);
        end
    end

endmodule

// File: rtl/te_onehot_enc.sv
module te_onehot_enc #(
    parameter int unsigned N = 3,
    parameter int unsigned W = 7
) (
    input  logic [W-1:0] fix_i,
    output logic [N-1:0] code_o
);

    logic [W:0] fix_ext;
    logic [W:0] edge_oh;

    assign fix_ext = {1'b0, fix_i};
    assign edge_oh[0] = ~fix_i[0];

    genvar gi;
    generate
        for (gi = 1; gi <= W; gi++) begin : g_edge
            assign edge_oh[gi] = fix_ext[gi-1] & ~fix_ext[gi];
        end
    endgenerate

    always_comb begin
        code_o = '0;
        for (int p = 1; p <= W; p++) begin
            if (edge_oh[p]) begin
                code_o = code_o | N'(p);
            end
        end
    end

    // R2: a clean word marks exactly one edge
    always_comb begin
        if (!$isunknown(fix_i) && ((fix_i & (fix_i + W'(1))) == '0)) begin
            single_edge_chk: assert ($onehot(edge_oh));
        end
    end

endmodule

// File: rtl/thermo_bin_encoder.sv
module thermo_bin_encoder
    import therm_enc_pkg::*;
#(
    parameter int unsigned N = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sample_i,
    input  logic [(1 << N) - 2:0] therm_i,
    output logic [N-1:0]          code_o,
    output logic                  valid_o
);

    localparam int unsigned W = (1 << N) - 1;

    typedef struct packed {
        logic         vld;
        logic [W-1:0] word;
    } cap_t;

    cap_t         cap_q;
    logic [W-1:0] fixed;
    logic [N-1:0] code_next;

    te_capture #(.W(W)) u_capture (
        .clk      (clk),
        .rst      (rst),
        .sample_i (sample_i),
        .therm_i  (therm_i),
        .word_o   (cap_q.word),
        .vld_o    (cap_q.vld)
    );

    te_bubble_fix #(.W(W)) u_fix (
        .raw_i (cap_q.word),
        .fix_o (fixed)
    );

    te_onehot_enc #(.N(N), .W(W)) u_enc (
        .fix_i  (fixed),
        .code_o (code_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            code_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= cap_q.vld;
            if (cap_q.vld) begin
                code_o <= code_next;
            end
        end
    end

    // R6
    result_follows_chk: assert property (@(posedge clk) disable iff (rst)
        cap_q.vld |=> valid_o);

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cap_q.vld |=> (!valid_o && $stable(code_o)));

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!valid_o && code_o == '0));

endmodule

// File: tb/thermo_bin_encoder_tb.sv
`timescale 1ns/1ps
module thermo_bin_encoder_tb;

    localparam int N = 3;
    localparam int W = (1 << N) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sample_i = 1'b0;
    logic [W-1:0] therm_i = '0;
    logic [N-1:0] code_o;
    logic         valid_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    thermo_bin_encoder #(.N(N)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .sample_i (sample_i),
        .therm_i  (therm_i),
        .code_o   (code_o),
        .valid_o  (valid_o)
    );

    // expected count for a run of k with bit j flipped (j < 0: no flip)
    function automatic int expect_code(input int k, input int j);
        if (j < 0) return k;
        if (j < k) return (j == k - 1) ? k - 1 : k;
        if (j == k) return k + 1;
        if (j == k + 1) return k + 2;
        return k;
    endfunction

    function automatic logic [W-1:0] make_word(input int k, input int j);
        logic [W-1:0] w;
        w = '0;
        for (int b = 0; b < k; b++) w[b] = 1'b1;
        if (j >= 0) w[j] = ~w[j];
        return w;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic string tag_for(input int k, input int j);
        if (j < 0) return (k == W) ? "R1/R2" : "R2";
        if (j < k - 1) return "R3";
        if (j == k + 1) return "R5";
        if (j > k + 1) return "R4";
        return "R2";
    endfunction

    task automatic apply(input int k, input int j);
        logic [W-1:0] w;
        int exp;
        w = make_word(k, j);
        exp = expect_code(k, j);
        @(negedge clk);
        therm_i = w;
        sample_i = 1'b1;
        @(negedge clk);
        sample_i = 1'b0;
        therm_i = ~w;
        check(valid_o == 1'b0, "R6 early", int'(valid_o), 0);
        @(negedge clk);
        check(valid_o == 1'b1, "R6 valid", int'(valid_o), 1);
        check(int'(code_o) == exp, tag_for(k, j), int'(code_o), exp);
        therm_i = '1;
        @(negedge clk);
        check(valid_o == 1'b0 && int'(code_o) == exp, "R7 hold", int'(code_o), exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(valid_o == 1'b0, "R8 valid", int'(valid_o), 0);
        check(code_o == '0, "R8 code", int'(code_o), 0);
        rst = 1'b0;

        for (int k = 0; k <= W; k++) begin
            apply(k, -1);
            for (int j = 0; j < W; j++) apply(k, j);
        end

        // back-to-back strobes
        for (int c = 0; c < W + 3; c++) begin
            @(negedge clk);
            if (c >= 2) begin
                check(valid_o == 1'b1, "R6 stream valid", int'(valid_o), 1);
                check(int'(code_o) == c - 2, "R6 stream", int'(code_o), c - 2);
            end
            if (c <= W) begin
                therm_i = make_word(c, -1);
                sample_i = 1'b1;
            end else begin
                sample_i = 1'b0;
                therm_i = '0;
            end
        end
        @(negedge clk);
        check(valid_o == 1'b0, "R6 stream end", int'(valid_o), 0);

        // strobe during reset is dropped
        therm_i = make_word(5, -1);
        sample_i = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        sample_i = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check(valid_o == 1'b0, "R8 drop", int'(valid_o), 0);
        @(negedge clk);
        check(valid_o == 1'b0 && code_o == '0, "R8 drop code", int'(code_o), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule